// File: doc/BRIEF.md
# Repeat-Next-Instruction Sequencer

This block sits in a processor's fetch and decode path and handles the repeat instruction. When a repeat word reaches decode, the block loads an 8-bit repeat count. The count comes either from the immediate byte of the word or from the low byte of a data word read from memory. The block then holds the program counter so that the following instruction issues the loaded count plus two times in a row. When the repetition ends, the PC moves past the repeated instruction.

Interrupt requests that arrive during the repeat instruction or during any repetition are not serviced at once. They collapse into a single pending bit. That bit produces one grant pulse in the first idle cycle after the final repetition.

The memory-source form spends one extra cycle capturing the read data before repetition begins. A follower that the decoder does not mark repeatable runs exactly once. So does a follower that is itself a repeat word.

Top module: `rpt_seq`

## Requirements
- R1: Instruction words are 17 bits. Bits 16..8 equal to 9'h1F8 mark the immediate form, and 9'h1BE marks the memory-source form. Any other prefix is an ordinary instruction: in the idle state it gives issue_o=1 and pc_hold_o=0 every cycle.
- R2: The repeat word itself issues for one cycle with pc_hold_o=0. With the immediate form and a repeatable follower, the follower then issues (bits 7..0 + 2) times on consecutive cycles.
- R3: The memory-source form adds one capture cycle straight after the repeat word, with issue_o=0 and pc_hold_o=1. Only bits 7..0 of mem_rdata_i in that cycle form the count, and the follower then issues (count + 2) times.
- R4: pc_hold_o is 1 on every issue of the follower except the last and 0 on the last, so across a repetition of N issues it is high exactly N-1 times.
- R5: If repeatable_i is 0 when the follower is presented, the follower issues exactly once with pc_hold_o=0, and the next word is handled as a fresh instruction.
- R6: A follower that is itself a repeat word (either prefix) is treated as not repeatable. It issues once, starts no new repeat and adds no capture cycle.
- R7: Requests on irq_i from the repeat word's cycle through the last repetition keep irq_grant_o at 0 throughout. Any number of them yields exactly one one-cycle grant, in the cycle right after the last issue.
- R8: In the idle state, a request on irq_i (with no repeat word being decoded) gives a one-cycle grant in the next cycle.
- R9: For the immediate form with a repeatable follower, the repeat word plus its repetitions take exactly count + 3 cycles before the next fetch is issued.
- R10: After synchronous reset the block is idle: issue_o=1, pc_hold_o=0, irq_grant_o=0, with no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 17 | Instruction word at decode |
| mem_rdata_i | input | 16 | Data word read for the memory-source form |
| repeatable_i | input | 1 | Decoder marks the presented word as repeatable |
| irq_i | input | 1 | Interrupt request |
| issue_o | output | 1 | Presented word issues this cycle |
| pc_hold_o | output | 1 | Keep the PC on the current word |
| irq_grant_o | output | 1 | Interrupt service may start |

## Verification
The assertions check several properties on every cycle. No grant appears while a repeat is active. A cycle without issue is always followed by an issue. A held issue is always followed by another issue. A memory-form word always leads to the capture cycle. A non-repeatable follower never holds the PC. A grant with no new request lasts one cycle. Only the bench's scenarios can show exact repetition counts, the count+3 latency, use of only the low data byte, the single grant after several queued requests, and the handling of nested repeat words. It shows these by sweeping every immediate count and a spread of memory values.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int INSTR_W = 17;
    localparam int OPND_W  = 8;
    localparam int PFX_W   = INSTR_W - OPND_W;

    localparam logic [PFX_W-1:0] PFX_IMM = 9'h1F8;
    localparam logic [PFX_W-1:0] PFX_MEM = 9'h1BE;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARMED,
        ST_REPEAT
    } seq_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_IMM,
        K_MEM
    } rpt_kind_e;

    typedef struct packed {
        rpt_kind_e          kind;
        logic [OPND_W-1:0]  operand;
    } rpt_dec_t;

    function automatic rpt_dec_t rpt_decode_word(input logic [INSTR_W-1:0] w);
        rpt_dec_t d;
        d.operand = w[OPND_W-1:0];
        if (w[INSTR_W-1:OPND_W] == PFX_IMM)
            d.kind = K_IMM;
        else if (w[INSTR_W-1:OPND_W] == PFX_MEM)
            d.kind = K_MEM;
        else
            d.kind = K_NONE;
        return d;
    endfunction

endpackage

// File: rtl/rpt_decode.sv
module rpt_decode
    import rpt_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output rpt_dec_t           dec_o,
    output logic               is_rpt_o
);
    always_comb begin
        dec_o    = rpt_decode_word(word_i);
        is_rpt_o = (dec_o.kind != K_NONE);
    end
endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          clr,
    input  logic          start,
    input  logic          step,
    output logic          last_o
);
    localparam int RW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [RW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (clr || start) begin
            cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (start) begin
            rem_q <= {1'b0, cnt_q} + RW'(1);
        end else if (step && rem_q != '0) begin
            rem_q <= rem_q - RW'(1);
        end
    end

    assign last_o = (rem_q == RW'(1));
endmodule

// File: rtl/rpt_irq_hold.sv
module rpt_irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic irq_i,
    input  logic release_i,
    output logic grant_o
);
    logic pend_q;

    assign grant_o = pend_q && release_i;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= irq_i || (pend_q && !grant_o);
    end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
    import rpt_pkg::*;
#(
    parameter int MEM_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [MEM_W-1:0]   mem_rdata_i,
    input  logic               repeatable_i,
    input  logic               irq_i,
    output logic               issue_o,
    output logic               pc_hold_o,
    output logic               irq_grant_o
);
    localparam int CW = OPND_W;

    seq_state_e state_q, state_d;
    rpt_dec_t   dec;
    logic       is_rpt;
    logic       ld_en, clr, start, step, last;
    logic [CW-1:0] ld_val;
    logic       idle_release;
    logic [CW-1:0] mem_low;

    assign mem_low = CW'(mem_rdata_i);

    rpt_decode u_dec (
        .word_i   (instr_i),
        .dec_o    (dec),
        .is_rpt_o (is_rpt)
    );

    rpt_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_en  (ld_en),
        .load_val (ld_val),
        .clr      (clr),
        .start    (start),
        .step     (step),
        .last_o   (last)
    );

    rpt_irq_hold u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_i     (irq_i),
        .release_i (idle_release),
        .grant_o   (irq_grant_o)
    );

    always_comb begin
        state_d      = state_q;
        issue_o      = 1'b1;
        pc_hold_o    = 1'b0;
        ld_en        = 1'b0;
        ld_val       = dec.operand;
        clr          = 1'b0;
        start        = 1'b0;
        step         = 1'b0;
        idle_release = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle_release = !is_rpt;
                if (dec.kind == K_IMM) begin
                    ld_en   = 1'b1;
                    state_d = ST_ARMED;
                end else if (dec.kind == K_MEM) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                issue_o   = 1'b0;
                pc_hold_o = 1'b1;
                ld_en     = 1'b1;
                ld_val    = mem_low;
                state_d   = ST_ARMED;
            end
            ST_ARMED: begin
                if (repeatable_i && !is_rpt) begin
                    pc_hold_o = 1'b1;
                    start     = 1'b1;
                    state_d   = ST_REPEAT;
                end else begin
                    clr     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_REPEAT: begin
                step      = 1'b1;
                pc_hold_o = !last;
                if (last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/rpt_seq_chk.sv
module rpt_seq_chk
    import rpt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr_i,
    input logic               repeatable_i,
    input logic               irq_i,
    input logic               issue_o,
    input logic               pc_hold_o,
    input logic               irq_grant_o,
    input seq_state_e         state_q
);
    // R7
    grant_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !irq_grant_o);

    // R3
    stall_once_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_o |=> issue_o);

    // R3
    mem_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && instr_i[INSTR_W-1:OPND_W] == PFX_MEM)
        |=> (!issue_o && pc_hold_o));

    // R4
    hold_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_o && pc_hold_o) |=> issue_o);

    // R5
    norep_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && !repeatable_i) |-> !pc_hold_o);

    // R8
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_grant_o && !irq_i) |=> !irq_grant_o);
endmodule

bind rpt_seq rpt_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_i      (instr_i),
    .repeatable_i (repeatable_i),
    .irq_i        (irq_i),
    .issue_o      (issue_o),
    .pc_hold_o    (pc_hold_o),
    .irq_grant_o  (irq_grant_o),
    .state_q      (state_q)
);

// File: tb/rpt_seq_tb_top.sv
`timescale 1ns/1ps
module rpt_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] instr = 17'h0;
    logic [15:0] mem_rdata = 16'h0;
    logic        rep = 1'b0;
    logic        irq = 1'b0;
    logic        issue, hold, grant;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    localparam logic [16:0] NOP    = 17'h00000;
    localparam logic [16:0] FOLLOW = 17'h00123;

    always #2 clk = ~clk;

    rpt_seq dut_i (
        .clk          (clk),
        .rst          (rst),
        .instr_i      (instr),
        .mem_rdata_i  (mem_rdata),
        .repeatable_i (rep),
        .irq_i        (irq),
        .issue_o      (issue),
        .pc_hold_o    (hold),
        .irq_grant_o  (grant)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 200000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_rpt(input bit mem, input int val, input bit rp, input bit irq_en);
        int issues = 0;
        int holds = 0;
        int total = 1;
        bit gseen = 0;
        int exp;
        @(negedge clk);
        instr = mem ? {9'h1BE, 8'h40} : {9'h1F8, 8'(val)};
        rep = 1'b0;
        irq = irq_en;
        #1;
        chk(issue && !hold && !grant, "R2 repeat word single issue", {issue, hold, grant}, 3'b100);
        if (mem) begin
            @(negedge clk);
            instr = FOLLOW;
            mem_rdata = {8'hA5 ^ 8'(val), 8'(val)};
            rep = rp;
            irq = 1'b0;
            #1;
            chk(!issue && hold && !grant, "R3 capture cycle", {issue, hold}, 2'b01);
            total++;
        end
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            instr = FOLLOW;
            mem_rdata = 16'hFFFF;
            rep = rp;
            irq = irq_en && (i % 2 == 0);
            #1;
            total++;
            if (issue) issues++;
            if (hold) holds++;
            if (grant) gseen = 1;
            if (!hold) break;
        end
        exp = rp ? val + 2 : 1;
        chk(issues == exp, rp ? (mem ? "R3 memory count" : "R2 immediate count") : "R5 non-repeatable once",
            issues, exp);
        chk(holds == exp - 1, "R4 hold count", holds, exp - 1);
        chk(!gseen, "R7 grant masked during repeat", gseen, 0);
        if (!mem && rp)
            chk(total == val + 3, "R9 total latency", total, val + 3);
        @(negedge clk);
        instr = NOP;
        rep = 1'b0;
        irq = 1'b0;
        #1;
        chk(grant == irq_en, "R7 grant after last issue", grant, irq_en);
        chk(issue && !hold, "R5 next word fresh", {issue, hold}, 2'b10);
        @(negedge clk);
        #1;
        chk(!grant, "R7 single grant pulse", grant, 0);
    endtask

    task automatic nested(input logic [16:0] inner);
        @(negedge clk);
        instr = {9'h1F8, 8'd5};
        rep = 1'b0;
        #1;
        @(negedge clk);
        instr = inner;
        rep = 1'b1;
        #1;
        chk(issue && !hold, "R6 nested repeat issues once", {issue, hold}, 2'b10);
        @(negedge clk);
        instr = NOP;
        rep = 1'b1;
        #1;
        chk(issue && !hold, "R6 no capture or new repeat", {issue, hold}, 2'b10);
        @(negedge clk);
        #1;
        chk(issue && !hold, "R6 stays idle", {issue, hold}, 2'b10);
        rep = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10
        chk(issue && !hold && !grant, "R10 reset state", {issue, hold, grant}, 3'b100);

        // R1: every other prefix is ordinary
        for (int p = 0; p < 512; p++) begin
            if (p == 9'h1F8 || p == 9'h1BE) continue;
            @(negedge clk);
            instr = {9'(p), 8'h37};
            #1;
            chk(issue && !hold && !grant, "R1 ordinary word", {issue, hold}, 2'b10);
        end

        // R8
        @(negedge clk);
        instr = NOP;
        irq = 1'b1;
        #1;
        chk(!grant, "R8 no same-cycle grant", grant, 0);
        @(negedge clk);
        irq = 1'b0;
        #1;
        chk(grant, "R8 idle grant", grant, 1);
        @(negedge clk);
        #1;
        chk(!grant, "R8 grant one cycle", grant, 0);

        // R2 R4 R7 R9 immediate sweep
        for (int v = 0; v < 256; v++)
            run_rpt(1'b0, v, 1'b1, v[0]);
        // R5
        for (int v = 0; v < 256; v += 51)
            run_rpt(1'b0, v, 1'b0, 1'b1);
        // R3 memory form
        for (int v = 0; v < 256; v += 17)
            run_rpt(1'b1, v, 1'b1, v[1]);
        run_rpt(1'b1, 255, 1'b1, 1'b1);
        run_rpt(1'b1, 9, 1'b0, 1'b0);

        // R6
        nested({9'h1F8, 8'd3});
        nested({9'h1BE, 8'd3});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule